// File: doc/BRIEF.md
# Compressed-Aware Instruction Fetch Sequencer

This block fetches a single instruction for a program counter in 16-bit pieces, so that both 16-bit compressed and 32-bit instructions can be fetched. A fetch begins with a one-cycle start strobe that carries the PC and a flag saying whether compressed instructions are allowed. The block first checks the PC for alignment. It then sends the low halfword address to an execute-type address-translation port and reads two bytes at the physical address that comes back.

If those two bytes encode a compressed instruction, the fetch ends at that point. Otherwise the block translates PC+2 as a separate request and reads the upper two bytes from their own physical address. It then returns the 32-bit instruction.

Every outcome ends with a one-cycle done pulse. The result is either an instruction, with a flag that marks it as compressed, or an exception cause together with the virtual address of the exact halfword that failed. Both the translation port and the memory port use a valid/ready request handshake and a single-cycle response strobe.

Top module: `ifetch_seq`

## Requirements
- R1: A PC with bit 0 set ends the fetch with exception cause 0 (address misaligned) and fault address equal to the PC. No translation or memory request is issued.
- R2: A PC with bit 1 set ends as R1 describes when compressed instructions are disabled. When they are enabled, the same PC is fetched normally. A PC with bits [1:0]=00 is fetched normally in both settings.
- R3: The first translation request carries the PC. The first memory read is issued at exactly the physical address returned by that translation.
- R4: A translation response with its fault flag set ends the fetch with the cause supplied by the translator. The fault address is the virtual address of that half: PC for the low half, PC+2 for the upper half.
- R5: A memory response with its error flag set ends the fetch with cause 1 (instruction access fault). The fault address is PC for the low half and PC+2 for the upper half.
- R6: A low halfword whose bits [1:0] are not 11 completes the fetch as a compressed instruction. The result is the halfword zero-extended to 32 bits, the compressed flag is 1, and no request for the upper half is made.
- R7: A low halfword whose bits [1:0] are 11 causes a second, independent translation of PC+2 and a 2-byte read at its result. The instruction is {upper halfword, low halfword} and the compressed flag is 0.
- R8: A request stays valid, with a stable address, until ready is seen. A response is accepted only after its request has been accepted. At most one of the two ports requests at any time.
- R9: The done pulse lasts one cycle. Instruction, compressed flag, exception flag, cause and fault address change only at a completion, and then hold until the next one.
- R10: A start strobe that arrives while a fetch is in progress is ignored. It causes no second completion and does not change the PC being fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| pc_i | input | XLEN | Program counter to fetch |
| comp_en_i | input | 1 | Compressed instructions enabled |
| xreq_valid_o | output | 1 | Translation request valid (execute access) |
| xreq_ready_i | input | 1 | Translation request accepted |
| xreq_vaddr_o | output | XLEN | Virtual halfword address to translate |
| xrsp_valid_i | input | 1 | Translation response strobe |
| xrsp_fault_i | input | 1 | Translation failed |
| xrsp_cause_i | input | CAUSE_W | Exception cause of a failed translation |
| xrsp_paddr_i | input | XLEN | Physical address of a successful translation |
| mreq_valid_o | output | 1 | 2-byte memory read request valid |
| mreq_ready_i | input | 1 | Memory request accepted |
| mreq_addr_o | output | XLEN | Physical address to read |
| mrsp_valid_i | input | 1 | Memory response strobe |
| mrsp_err_i | input | 1 | Memory read error |
| mrsp_data_i | input | 16 | Halfword read |
| done_o | output | 1 | One-cycle completion pulse |
| compressed_o | output | 1 | Result is a 16-bit instruction |
| instr_o | output | 32 | Fetched instruction |
| exc_valid_o | output | 1 | Fetch ended in an exception |
| exc_cause_o | output | CAUSE_W | Exception cause |
| exc_addr_o | output | XLEN | Virtual address of the failing halfword |

## Verification
A sequencer stuck in the wrong state shows up at the ports in one of three ways, each within a handshake or two. A wrong or missing request appears on a port, an address that belongs to the other half appears on the request lines, or a completion reports the wrong halfword. Losing track of the compressed test either drops the upper-half request or adds one that should not be there. A request count taken at the ports exposes that at once. Results that change outside a completion, or a done pulse longer than one cycle, break the stability rules on the next cycle.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;

   typedef enum logic [2:0] {
      FS_IDLE,
      FS_XLATE_LO,
      FS_READ_LO,
      FS_XLATE_HI,
      FS_READ_HI,
      FS_DONE
   } fetch_state_e;

   localparam int unsigned HALF_W  = 16;
   localparam int unsigned INSTR_W = 2 * HALF_W;

   // a halfword whose two low bits are both set opens a 32-bit instruction
   function automatic logic opens_full(input logic [HALF_W-1:0] h);
      return h[1:0] == 2'b11;
   endfunction

endpackage

// File: rtl/ifetch_hs_chan.sv
module ifetch_hs_chan #(
   parameter int unsigned AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          active_i,
   input  logic [AW-1:0] addr_i,
   output logic          req_valid_o,
   input  logic          req_ready_i,
   output logic [AW-1:0] req_addr_o,
   input  logic          rsp_valid_i,
   output logic          rsp_take_o
);
   logic sent_q;
   logic fire;

   assign req_valid_o = active_i & ~sent_q;
   assign req_addr_o  = addr_i;
   assign fire        = req_valid_o & req_ready_i;
   assign rsp_take_o  = active_i & sent_q & rsp_valid_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sent_q <= 1'b0;
      else if (!active_i || rsp_take_o)
         sent_q <= 1'b0;
      else if (fire)
         sent_q <= 1'b1;
   end
endmodule

// File: rtl/ifetch_fsm.sv
module ifetch_fsm
   import ifetch_pkg::*;
#(
   parameter int unsigned XLEN        = 32,
   parameter int unsigned CAUSE_W     = 4,
   parameter logic [CAUSE_W-1:0] CAUSE_MISALIGN = '0,
   parameter logic [CAUSE_W-1:0] CAUSE_ACCESS   = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [XLEN-1:0]     pc_i,
   input  logic                comp_en_i,
   output logic                x_active_o,
   output logic [XLEN-1:0]     x_addr_o,
   input  logic                x_take_i,
   input  logic                x_fault_i,
   input  logic [CAUSE_W-1:0]  x_cause_i,
   input  logic [XLEN-1:0]     x_paddr_i,
   output logic                m_active_o,
   output logic [XLEN-1:0]     m_addr_o,
   input  logic                m_take_i,
   input  logic                m_err_i,
   input  logic [HALF_W-1:0]   m_data_i,
   output logic                fin_o,
   output logic                fin_exc_o,
   output logic [CAUSE_W-1:0]  fin_cause_o,
   output logic [XLEN-1:0]     fin_addr_o,
   output logic [INSTR_W-1:0]  fin_instr_o,
   output logic                fin_comp_o,
   output logic                done_o
);
   localparam logic [XLEN-1:0] HALF_STEP = XLEN'(HALF_W / 8);

   fetch_state_e          state_q, state_d;
   logic [XLEN-1:0]       pc_q, pc_d, paddr_q, paddr_d, pc_hi;
   logic [HALF_W-1:0]     lo_q, lo_d;
   logic                  misaligned;

   assign pc_hi      = pc_q + HALF_STEP;
   assign misaligned = pc_i[0] | (pc_i[1] & ~comp_en_i);

   assign x_active_o = (state_q == FS_XLATE_LO) | (state_q == FS_XLATE_HI);
   assign m_active_o = (state_q == FS_READ_LO)  | (state_q == FS_READ_HI);
   assign x_addr_o   = (state_q == FS_XLATE_HI) ? pc_hi : pc_q;
   assign m_addr_o   = paddr_q;
   assign done_o     = (state_q == FS_DONE);

   always_comb begin
      state_d     = state_q;
      pc_d        = pc_q;
      paddr_d     = paddr_q;
      lo_d        = lo_q;
      fin_o       = 1'b0;
      fin_exc_o   = 1'b0;
      fin_cause_o = '0;
      fin_addr_o  = '0;
      fin_instr_o = '0;
      fin_comp_o  = 1'b0;
      unique case (state_q)
         FS_IDLE: begin
            if (start_i) begin
               pc_d = pc_i;
               if (misaligned) begin
                  fin_o       = 1'b1;
                  fin_exc_o   = 1'b1;
                  fin_cause_o = CAUSE_MISALIGN;
                  fin_addr_o  = pc_i;
                  state_d     = FS_DONE;
               end else begin
                  state_d = FS_XLATE_LO;
               end
            end
         end
         FS_XLATE_LO, FS_XLATE_HI: begin
            if (x_take_i) begin
               if (x_fault_i) begin
                  fin_o       = 1'b1;
                  fin_exc_o   = 1'b1;
                  fin_cause_o = x_cause_i;
                  fin_addr_o  = x_addr_o;
                  state_d     = FS_DONE;
               end else begin
                  paddr_d = x_paddr_i;
                  state_d = (state_q == FS_XLATE_LO) ? FS_READ_LO : FS_READ_HI;
               end
            end
         end
         FS_READ_LO: begin
            if (m_take_i) begin
               if (m_err_i) begin
                  fin_o       = 1'b1;
                  fin_exc_o   = 1'b1;
                  fin_cause_o = CAUSE_ACCESS;
                  fin_addr_o  = pc_q;
                  state_d     = FS_DONE;
               end else if (!opens_full(m_data_i)) begin
                  fin_o       = 1'b1;
                  fin_comp_o  = 1'b1;
                  fin_instr_o = {{(INSTR_W-HALF_W){1'b0}}, m_data_i};
                  state_d     = FS_DONE;
               end else begin
                  lo_d    = m_data_i;
                  state_d = FS_XLATE_HI;
               end
            end
         end
         FS_READ_HI: begin
            if (m_take_i) begin
               fin_o = 1'b1;
               if (m_err_i) begin
                  fin_exc_o   = 1'b1;
                  fin_cause_o = CAUSE_ACCESS;
                  fin_addr_o  = pc_hi;
               end else begin
                  fin_instr_o = {m_data_i, lo_q};
               end
               state_d = FS_DONE;
            end
         end
         FS_DONE:  state_d = FS_IDLE;
         default:  state_d = FS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FS_IDLE;
         pc_q    <= '0;
         paddr_q <= '0;
         lo_q    <= '0;
      end else begin
         state_q <= state_d;
         pc_q    <= pc_d;
         paddr_q <= paddr_d;
         lo_q    <= lo_d;
      end
   end
endmodule

// File: rtl/ifetch_result.sv
module ifetch_result
   import ifetch_pkg::*;
#(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned CAUSE_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fin_i,
   input  logic               exc_i,
   input  logic [CAUSE_W-1:0] cause_i,
   input  logic [XLEN-1:0]    addr_i,
   input  logic [INSTR_W-1:0] instr_i,
   input  logic               comp_i,
   output logic               exc_valid_o,
   output logic [CAUSE_W-1:0] exc_cause_o,
   output logic [XLEN-1:0]    exc_addr_o,
   output logic [INSTR_W-1:0] instr_o,
   output logic               compressed_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exc_valid_o  <= 1'b0;
         exc_cause_o  <= '0;
         exc_addr_o   <= '0;
         instr_o      <= '0;
         compressed_o <= 1'b0;
      end else if (fin_i) begin
         exc_valid_o  <= exc_i;
         exc_cause_o  <= cause_i;
         exc_addr_o   <= addr_i;
         instr_o      <= instr_i;
         compressed_o <= comp_i;
      end
   end
endmodule

// File: rtl/ifetch_seq.sv
module ifetch_seq
   import ifetch_pkg::*;
#(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned CAUSE_W = 4,
   parameter logic [CAUSE_W-1:0] CAUSE_MISALIGN = '0,
   parameter logic [CAUSE_W-1:0] CAUSE_ACCESS   = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [XLEN-1:0]    pc_i,
   input  logic               comp_en_i,
   output logic               xreq_valid_o,
   input  logic               xreq_ready_i,
   output logic [XLEN-1:0]    xreq_vaddr_o,
   input  logic               xrsp_valid_i,
   input  logic               xrsp_fault_i,
   input  logic [CAUSE_W-1:0] xrsp_cause_i,
   input  logic [XLEN-1:0]    xrsp_paddr_i,
   output logic               mreq_valid_o,
   input  logic               mreq_ready_i,
   output logic [XLEN-1:0]    mreq_addr_o,
   input  logic               mrsp_valid_i,
   input  logic               mrsp_err_i,
   input  logic [15:0]        mrsp_data_i,
   output logic               done_o,
   output logic               compressed_o,
   output logic [31:0]        instr_o,
   output logic               exc_valid_o,
   output logic [CAUSE_W-1:0] exc_cause_o,
   output logic [XLEN-1:0]    exc_addr_o
);
   generate
      if (XLEN < HALF_W || (XLEN % 2) != 0) begin : g_bad_xlen
         $error("ifetch_seq: XLEN must be even and at least one halfword");
      end
      if (CAUSE_W < 1 || CAUSE_MISALIGN == CAUSE_ACCESS) begin : g_bad_cause
         $error("ifetch_seq: cause codes must be distinct and non-empty");
      end
   endgenerate

   logic               x_active, m_active, x_take, m_take;
   logic [XLEN-1:0]    x_addr, m_addr, fin_addr;
   logic               fin, fin_exc, fin_comp;
   logic [CAUSE_W-1:0] fin_cause;
   logic [INSTR_W-1:0] fin_instr;

   ifetch_fsm #(
      .XLEN(XLEN), .CAUSE_W(CAUSE_W),
      .CAUSE_MISALIGN(CAUSE_MISALIGN), .CAUSE_ACCESS(CAUSE_ACCESS)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .pc_i(pc_i), .comp_en_i(comp_en_i),
      .x_active_o(x_active), .x_addr_o(x_addr), .x_take_i(x_take),
      .x_fault_i(xrsp_fault_i), .x_cause_i(xrsp_cause_i), .x_paddr_i(xrsp_paddr_i),
      .m_active_o(m_active), .m_addr_o(m_addr), .m_take_i(m_take),
      .m_err_i(mrsp_err_i), .m_data_i(mrsp_data_i),
      .fin_o(fin), .fin_exc_o(fin_exc), .fin_cause_o(fin_cause), .fin_addr_o(fin_addr),
      .fin_instr_o(fin_instr), .fin_comp_o(fin_comp), .done_o(done_o)
   );

   ifetch_hs_chan #(.AW(XLEN)) u_xchan (
      .clk(clk), .rst_n(rst_n), .active_i(x_active), .addr_i(x_addr),
      .req_valid_o(xreq_valid_o), .req_ready_i(xreq_ready_i), .req_addr_o(xreq_vaddr_o),
      .rsp_valid_i(xrsp_valid_i), .rsp_take_o(x_take)
   );

   ifetch_hs_chan #(.AW(XLEN)) u_mchan (
      .clk(clk), .rst_n(rst_n), .active_i(m_active), .addr_i(m_addr),
      .req_valid_o(mreq_valid_o), .req_ready_i(mreq_ready_i), .req_addr_o(mreq_addr_o),
      .rsp_valid_i(mrsp_valid_i), .rsp_take_o(m_take)
   );

   ifetch_result #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_res (
      .clk(clk), .rst_n(rst_n), .fin_i(fin), .exc_i(fin_exc), .cause_i(fin_cause),
      .addr_i(fin_addr), .instr_i(fin_instr), .comp_i(fin_comp),
      .exc_valid_o(exc_valid_o), .exc_cause_o(exc_cause_o), .exc_addr_o(exc_addr_o),
      .instr_o(instr_o), .compressed_o(compressed_o)
   );
endmodule

// File: rtl/ifetch_seq_chk.sv
module ifetch_seq_chk #(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned CAUSE_W = 4,
   parameter logic [CAUSE_W-1:0] CAUSE_MISALIGN = '0
) (
   input logic               clk,
   input logic               rst_n,
   input logic               xreq_valid_o,
   input logic               xreq_ready_i,
   input logic [XLEN-1:0]    xreq_vaddr_o,
   input logic               mreq_valid_o,
   input logic               mreq_ready_i,
   input logic [XLEN-1:0]    mreq_addr_o,
   input logic               done_o,
   input logic               compressed_o,
   input logic [31:0]        instr_o,
   input logic               exc_valid_o,
   input logic [CAUSE_W-1:0] exc_cause_o,
   input logic [XLEN-1:0]    exc_addr_o
);
   // R8
   xreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xreq_valid_o && !xreq_ready_i |=> xreq_valid_o && $stable(xreq_vaddr_o));

   // R8
   mreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mreq_valid_o && !mreq_ready_i |=> mreq_valid_o && $stable(mreq_addr_o));

   // R8
   one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({xreq_valid_o, mreq_valid_o}));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R9
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> done_o || ($stable(instr_o) && $stable(compressed_o) && $stable(exc_valid_o)
                          && $stable(exc_cause_o) && $stable(exc_addr_o)));

   // R6
   comp_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !exc_valid_o && compressed_o |-> instr_o[1:0] != 2'b11 && instr_o[31:16] == 16'h0);

   // R7
   full_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !exc_valid_o && !compressed_o |-> instr_o[1:0] == 2'b11);

   // R1
   mis_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && exc_valid_o && exc_cause_o == CAUSE_MISALIGN |-> exc_addr_o[0] || exc_addr_o[1]);
endmodule

bind ifetch_seq ifetch_seq_chk #(
   .XLEN(XLEN), .CAUSE_W(CAUSE_W), .CAUSE_MISALIGN(CAUSE_MISALIGN)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .xreq_valid_o(xreq_valid_o), .xreq_ready_i(xreq_ready_i), .xreq_vaddr_o(xreq_vaddr_o),
   .mreq_valid_o(mreq_valid_o), .mreq_ready_i(mreq_ready_i), .mreq_addr_o(mreq_addr_o),
   .done_o(done_o), .compressed_o(compressed_o), .instr_o(instr_o),
   .exc_valid_o(exc_valid_o), .exc_cause_o(exc_cause_o), .exc_addr_o(exc_addr_o)
);

// File: tb/tb_ifetch_seq.sv
module tb_ifetch_seq;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] POFS = 32'h0001_0000;
   localparam logic [3:0]  XCAUSE = 4'hC;

   typedef struct packed {
      logic [31:0] pc;
      logic        cen, xf_lo, xf_hi, me_lo, me_hi;
      logic [15:0] lo, hi;
      logic        exc;
      logic [3:0]  cause;
      logic [31:0] addr;
      logic [31:0] instr;
      logic        comp;
      logic [1:0]  nx;
   } fvec_t;

   localparam int NV = 11;
   localparam fvec_t VECS [NV] = '{
      '{32'h100, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0001, 16'h0000, 1'b0, 4'h0, 32'h0,   32'h0000_0001, 1'b1, 2'd1},
      '{32'h202, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h1113, 16'hABCD, 1'b0, 4'h0, 32'h0,   32'hABCD_1113, 1'b0, 2'd2},
      '{32'h301, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b1, 4'h0, 32'h301, 32'h0,         1'b0, 2'd0},
      '{32'h402, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b1, 4'h0, 32'h402, 32'h0,         1'b0, 2'd0},
      '{32'h500, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0003, 16'h0000, 1'b1, XCAUSE, 32'h500, 32'h0,       1'b0, 2'd1},
      '{32'h600, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0003, 16'h0000, 1'b1, XCAUSE, 32'h602, 32'h0,       1'b0, 2'd2},
      '{32'h700, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0003, 16'h0000, 1'b1, 4'h1, 32'h700, 32'h0,         1'b0, 2'd1},
      '{32'h800, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0003, 16'h0000, 1'b1, 4'h1, 32'h802, 32'h0,         1'b0, 2'd2},
      '{32'h900, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h1233, 16'h4567, 1'b0, 4'h0, 32'h0,   32'h4567_1233, 1'b0, 2'd2},
      '{32'hFFE, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h8003, 16'h7654, 1'b0, 4'h0, 32'h0,   32'h7654_8003, 1'b0, 2'd2},
      '{32'hC02, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h4562, 16'h0000, 1'b0, 4'h0, 32'h0,   32'h0000_4562, 1'b1, 2'd1}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic start_i = 1'b0, comp_en_i = 1'b0;
   logic [31:0] pc_i = '0;
   logic xreq_valid_o, xreq_ready_i = 1'b0;
   logic [31:0] xreq_vaddr_o;
   logic xrsp_valid_i = 1'b0, xrsp_fault_i = 1'b0;
   logic [3:0] xrsp_cause_i = '0;
   logic [31:0] xrsp_paddr_i = '0;
   logic mreq_valid_o, mreq_ready_i = 1'b0;
   logic [31:0] mreq_addr_o;
   logic mrsp_valid_i = 1'b0, mrsp_err_i = 1'b0;
   logic [15:0] mrsp_data_i = '0;
   logic done_o, compressed_o, exc_valid_o;
   logic [31:0] instr_o, exc_addr_o;
   logic [3:0] exc_cause_o;

   ifetch_seq dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .pc_i(pc_i), .comp_en_i(comp_en_i),
      .xreq_valid_o(xreq_valid_o), .xreq_ready_i(xreq_ready_i), .xreq_vaddr_o(xreq_vaddr_o),
      .xrsp_valid_i(xrsp_valid_i), .xrsp_fault_i(xrsp_fault_i), .xrsp_cause_i(xrsp_cause_i),
      .xrsp_paddr_i(xrsp_paddr_i),
      .mreq_valid_o(mreq_valid_o), .mreq_ready_i(mreq_ready_i), .mreq_addr_o(mreq_addr_o),
      .mrsp_valid_i(mrsp_valid_i), .mrsp_err_i(mrsp_err_i), .mrsp_data_i(mrsp_data_i),
      .done_o(done_o), .compressed_o(compressed_o), .instr_o(instr_o),
      .exc_valid_o(exc_valid_o), .exc_cause_o(exc_cause_o), .exc_addr_o(exc_addr_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0, errors = 0;
   fvec_t cur = '0;
   int stall = 0;
   int x_count = 0, m_count = 0;
   logic [31:0] x_first = '0, m_first = '0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // bench responders, driven at the falling edge
   initial begin
      bit xp = 0, mp = 0;
      int xw = 0, mw = 0;
      logic [31:0] xva = '0, mpa = '0;
      forever begin
         @(negedge clk);
         if (xp) begin
            xrsp_valid_i = 1'b1;
            xrsp_fault_i = (xva == cur.pc && cur.xf_lo) || (xva == cur.pc + 32'd2 && cur.xf_hi);
            xrsp_cause_i = XCAUSE;
            xrsp_paddr_i = xva + POFS;
            xp = 0;
         end else xrsp_valid_i = 1'b0;
         if (mp) begin
            mrsp_valid_i = 1'b1;
            mrsp_err_i   = (mpa == cur.pc + POFS) ? cur.me_lo : cur.me_hi;
            mrsp_data_i  = (mpa == cur.pc + POFS) ? cur.lo : cur.hi;
            mp = 0;
         end else mrsp_valid_i = 1'b0;
         xreq_ready_i = 1'b0;
         if (xreq_valid_o) begin
            if (xw < stall) xw++;
            else begin
               xreq_ready_i = 1'b1; xw = 0; xp = 1; xva = xreq_vaddr_o;
               if (x_count == 0) x_first = xreq_vaddr_o;
               x_count++;
            end
         end
         mreq_ready_i = 1'b0;
         if (mreq_valid_o) begin
            if (mw < stall) mw++;
            else begin
               mreq_ready_i = 1'b1; mw = 0; mp = 1; mpa = mreq_addr_o;
               if (m_count == 0) m_first = mreq_addr_o;
               m_count++;
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   function automatic string tag_of(input fvec_t v);
      if (v.exc && v.cause == 4'h0) return v.cen ? "R1" : "R2";
      if (v.exc && v.cause == XCAUSE) return "R4";
      if (v.exc) return "R5";
      if (v.comp) return "R6";
      return "R7";
   endfunction

   task automatic wait_done(output bit seen);
      int n = 0;
      while (!done_o && n < 500) begin @(negedge clk); n++; end
      seen = done_o;
   endtask

   task automatic launch(input logic [31:0] pc, input logic cen);
      @(negedge clk);
      start_i = 1'b1; pc_i = pc; comp_en_i = cen;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic run_vec(input fvec_t v);
      bit seen;
      string t;
      t = tag_of(v);
      cur = v; x_count = 0; m_count = 0;
      launch(v.pc, v.cen);
      wait_done(seen);
      chk(seen, t, 32'(seen), 32'd1);
      chk(exc_valid_o == v.exc, t, 32'(exc_valid_o), 32'(v.exc));
      if (v.exc) begin
         chk(exc_cause_o == v.cause, t, 32'(exc_cause_o), 32'(v.cause));
         chk(exc_addr_o == v.addr, t, exc_addr_o, v.addr);
      end else begin
         chk(instr_o == v.instr, t, instr_o, v.instr);
         chk(compressed_o == v.comp, t, 32'(compressed_o), 32'(v.comp));
      end
      chk(x_count == int'(v.nx), "R8 request count", 32'(x_count), 32'(v.nx));
      @(negedge clk);
      chk(!done_o, "R9 pulse", 32'(done_o), 32'd0);
   endtask

   initial begin
      bit seen;
      logic [31:0] held;
      repeat (3) @(negedge clk);
      // reset state
      chk(!done_o && !xreq_valid_o && !mreq_valid_o, "R9 reset idle", 32'(done_o), 32'd0);
      chk(!exc_valid_o && instr_o == 32'h0, "R9 reset result", instr_o, 32'h0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) run_vec(VECS[i]);

      // R3: first translation carries PC, first read uses returned physical address
      run_vec(VECS[1]);
      chk(x_first == 32'h202, "R3 xlate addr", x_first, 32'h202);
      chk(m_first == 32'h202 + POFS, "R3 read addr", m_first, 32'h202 + POFS);
      // R7: upper address crosses a page boundary, translated on its own
      run_vec(VECS[9]);
      chk(m_count == 2, "R7 two reads", 32'(m_count), 32'd2);
      // R1: misaligned makes no memory request either
      run_vec(VECS[2]);
      chk(m_count == 0, "R1 no read", 32'(m_count), 32'd0);
      // R6: compressed makes a single read
      run_vec(VECS[0]);
      chk(m_count == 1, "R6 single read", 32'(m_count), 32'd1);

      // R8 + R10: stalled handshakes, second start while busy
      stall = 3;
      cur = '{32'hA00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h2223, 16'h3333,
              1'b0, 4'h0, 32'h0, 32'h3333_2223, 1'b0, 2'd2};
      x_count = 0; m_count = 0;
      launch(32'hA00, 1'b1);
      @(negedge clk);
      start_i = 1'b1; pc_i = 32'hB00;
      @(negedge clk);
      start_i = 1'b0;
      wait_done(seen);
      chk(seen && instr_o == 32'h3333_2223, "R10 busy start", instr_o, 32'h3333_2223);
      chk(x_first == 32'hA00 && x_count == 2, "R8 stalled xlate", x_first, 32'hA00);
      chk(m_count == 2, "R8 stalled read", 32'(m_count), 32'd2);
      held = instr_o;
      seen = 0;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         if (done_o) seen = 1;
      end
      chk(!seen, "R10 no extra done", 32'(seen), 32'd0);
      chk(instr_o == held, "R9 result held", instr_o, held);
      chk(x_count == 2, "R10 no extra request", 32'(x_count), 32'd2);
      stall = 0;

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule